// File: doc/BRIEF.md
# Credit-Based Mailbox Thread

This block is a single messaging thread of a mailbox that is reached through a small register window. One control bit decides whether the thread sends or receives. The same status register reports a count in either direction, but the count means something different in each.

In the send direction, the count is the number of credits left. Software stages message words in the data window. Writing the final word completes the message: it spends one credit and forwards all fifteen words on a wide output bus. The far side gives credits back with a one-cycle pulse.

In the receive direction, the far side deposits words into a small message store and then commits them. The count is then the number of messages waiting, and an interrupt stays high while that number is nonzero. Reading the final word of the head message removes it from the store. Completing with no credits, or popping with nothing waiting, sets a sticky error flag.

Top module: `sp_thread`

## Requirements
- R1: The status register is at byte offset 0x0000. The control register is at 0x1000 and holds the direction in bit 31 (1 = receive, 0 = transmit; 0 after reset). Data word n (n = 0..14) is at offset 4 + 4n, and word 14 (offset 0x3C) is the completion word.
- R2: A status read returns the count in bits [7:0], the error flag in bit 31, and zeros elsewhere. The count is the credit count when transmitting and the pending count when receiving.
- R3: The credit count resets to INIT_CREDITS. A transmit-direction write to word 14 with credits above zero decrements the credit count. It also raises tx_valid for one cycle in the next cycle, with tx_msg[32n+:32] holding word n: the last value written for n = 0..13, and the completion data for n = 14.
- R4: A credit_ret pulse adds one credit, saturating at INIT_CREDITS. A credit return in the same cycle as a successful completion leaves the count unchanged.
- R5: A transmit completion with zero credits forwards nothing, leaves the count at zero and sets the error flag.
- R6: Far-side word writes (rx_word_we, rx_word_idx) fill the next slot, and an rx_commit pulse adds that message to the pending count, up to RX_DEPTH. While the store is full, both word writes and commits are ignored.
- R7: In the receive direction, a read of word n returns word n of the oldest pending message. A read of word 14 also removes that message.
- R8: A receive-direction read of word 14 with no message pending sets the error flag and changes no count.
- R9: Once set, the error flag stays set until reset, regardless of later traffic.
- R10: rx_irq is high exactly while the direction is receive and the pending count is nonzero.
- R11: Receive-direction writes to data words have no effect: no forwarding, no credit change, and no change to the staged transmit words. Transmit-direction reads of word 14 have no effect on credits or the error flag.
- R12: bus_rdata is valid in the cycle after a read request and reflects the state before that request. Transmit-direction reads of data words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte offset within the thread window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| credit_ret | input | 1 | Far side returns one credit |
| rx_word_we | input | 1 | Far side writes one word of an incoming message |
| rx_word_idx | input | 4 | Word index of that write |
| rx_word_data | input | 32 | Word value of that write |
| rx_commit | input | 1 | Far side publishes the filled message |
| tx_valid | output | 1 | Forwarded message present this cycle |
| tx_msg | output | 480 | Forwarded message, word n at bits [32n+31:32n] |
| rx_irq | output | 1 | Receive messages pending |

## Verification
Every request or far-side pulse takes effect at the rising edge that samples it. tx_valid, tx_msg and bus_rdata change at that same edge, so they are due in the very next cycle. The status count and rx_irq follow from registers updated at that edge, so a status read issued in the following cycle already sees the new count. The bench drives stimulus on falling edges and advances a behavioural reference model at each rising edge. On every falling edge it compares the outputs against the model, checking read data only in the cycle after a read.

// File: rtl/sp_thread_pkg.sv
package sp_thread_pkg;
  localparam int ADDR_W   = 13;
  localparam int DATA_W   = 32;
  localparam int CNT_BITS = 8;
  localparam logic [ADDR_W-1:0] STATUS_OFS = 13'h0000;
  localparam logic [ADDR_W-1:0] CTRL_OFS   = 13'h1000;

  typedef enum logic [1:0] {
    RSP_ZERO,
    RSP_SNAP,
    RSP_MEM
  } rsp_kind_e;
endpackage

// File: rtl/sp_addr_dec.sv
module sp_addr_dec
  import sp_thread_pkg::*;
#(
  parameter int MSG_WORDS = 15,
  parameter int IDX_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_status,
  output logic              is_ctrl,
  output logic              is_data,
  output logic              is_last,
  output logic [IDX_W-1:0]  idx
);
  localparam int WSEL_W = ADDR_W - 2;

  logic [WSEL_W-1:0] wsel;
  logic [WSEL_W-1:0] wnum;

  assign wsel      = addr[ADDR_W-1:2];
  assign wnum      = wsel - WSEL_W'(1);
  assign is_status = (addr == STATUS_OFS);
  assign is_ctrl   = (addr == CTRL_OFS);
  assign is_data   = (addr[1:0] == 2'b00) && (wsel >= WSEL_W'(1)) &&
                     (wsel <= WSEL_W'(MSG_WORDS));
  assign idx       = wnum[IDX_W-1:0];
  assign is_last   = is_data && (wnum == WSEL_W'(MSG_WORDS - 1));
endmodule

// File: rtl/sp_credit_ctr.sv
module sp_credit_ctr #(
  parameter int INIT_CREDITS = 4,
  parameter int CW           = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CEIL = CW'(INIT_CREDITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= CEIL;
    end else if (take && !give) begin
      count <= count - CW'(1);
    end else if (give && !take && (count != CEIL)) begin
      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/sp_tx_stage.sv
module sp_tx_stage #(
  parameter int MSG_WORDS = 15,
  parameter int IDX_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [31:0]             wdata,
  input  logic                    fire,
  input  logic [31:0]             fire_data,
  output logic                    tx_valid,
  output logic [MSG_WORDS*32-1:0] tx_msg
);
  localparam int STAGED = MSG_WORDS - 1;

  logic [31:0]          stage [STAGED];
  logic [STAGED*32-1:0] stage_flat;

  for (genvar g = 0; g < STAGED; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[g] <= '0;
      end else if (we && (idx == IDX_W'(g))) begin
        stage[g] <= wdata;
      end
    end
    assign stage_flat[32*g +: 32] = stage[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_msg   <= '0;
    end else begin
      tx_valid <= fire;
      if (fire) begin
        tx_msg <= {fire_data, stage_flat};
      end
    end
  end
endmodule

// File: rtl/sp_rx_store.sv
module sp_rx_store #(
  parameter int RX_DEPTH = 4,
  parameter int IDX_W    = 4,
  parameter int PW       = 2,
  parameter int NW       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             commit,
  input  logic             pop,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data,
  output logic [NW-1:0]    pending
);
  localparam int MEM_DEPTH = RX_DEPTH * (2 ** IDX_W);

  logic [31:0]   mem [MEM_DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic          full;
  logic          do_commit;

  assign full      = (pending == NW'(RX_DEPTH));
  assign do_commit = commit && !full;

  always_ff @(posedge clk) begin
    if (wr_en && !full) begin
      mem[{wr_ptr, wr_idx}] <= wr_data;
    end
    rd_data <= mem[{rd_ptr, rd_idx}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      pending <= '0;
    end else begin
      if (do_commit) begin
        wr_ptr <= wr_ptr + PW'(1);
      end
      if (pop) begin
        rd_ptr <= rd_ptr + PW'(1);
      end
      case ({do_commit, pop})
        2'b10:   pending <= pending + NW'(1);
        2'b01:   pending <= pending - NW'(1);
        default: pending <= pending;
      endcase
    end
  end
endmodule

// File: rtl/sp_thread.sv
module sp_thread
  import sp_thread_pkg::*;
#(
  parameter int INIT_CREDITS = 4,
  parameter int RX_DEPTH     = 4,
  parameter int MSG_WORDS    = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [12:0]             bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    credit_ret,
  input  logic                    rx_word_we,
  input  logic [3:0]              rx_word_idx,
  input  logic [31:0]             rx_word_data,
  input  logic                    rx_commit,
  output logic                    tx_valid,
  output logic [MSG_WORDS*32-1:0] tx_msg,
  output logic                    rx_irq
);
  localparam int IDX_W = $clog2(MSG_WORDS);
  localparam int CW    = $clog2(INIT_CREDITS + 1);
  localparam int PW    = $clog2(RX_DEPTH);
  localparam int NW    = $clog2(RX_DEPTH + 1);

  logic             is_status, is_ctrl, is_data, is_last;
  logic [IDX_W-1:0] idx;
  logic             dir_rx;
  logic             err_q;
  logic [CW-1:0]    cred_cnt;
  logic [NW-1:0]    rx_pend;
  logic [31:0]      rx_rd_word;
  logic [31:0]      status_word;
  logic [31:0]      snap_q;
  rsp_kind_e        rsp_kind;
  logic             wr_req, rd_req;
  logic             tx_try, tx_fire, tx_err;
  logic             pop_try, pop_ok, pop_err;
  logic             stage_we;

  sp_addr_dec #(.MSG_WORDS(MSG_WORDS), .IDX_W(IDX_W)) u_dec (
    .addr      (bus_addr),
    .is_status (is_status),
    .is_ctrl   (is_ctrl),
    .is_data   (is_data),
    .is_last   (is_last),
    .idx       (idx)
  );

  assign wr_req   = bus_valid && bus_write;
  assign rd_req   = bus_valid && !bus_write;
  assign tx_try   = wr_req && is_last && !dir_rx;
  assign tx_fire  = tx_try && (cred_cnt != '0);
  assign tx_err   = tx_try && (cred_cnt == '0);
  assign pop_try  = rd_req && is_last && dir_rx;
  assign pop_ok   = pop_try && (rx_pend != '0);
  assign pop_err  = pop_try && (rx_pend == '0);
  assign stage_we = wr_req && is_data && !is_last && !dir_rx;

  sp_credit_ctr #(.INIT_CREDITS(INIT_CREDITS), .CW(CW)) u_cred (
    .clk   (clk),
    .rst   (rst),
    .take  (tx_fire),
    .give  (credit_ret),
    .count (cred_cnt)
  );

  sp_tx_stage #(.MSG_WORDS(MSG_WORDS), .IDX_W(IDX_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .we        (stage_we),
    .idx       (idx),
    .wdata     (bus_wdata),
    .fire      (tx_fire),
    .fire_data (bus_wdata),
    .tx_valid  (tx_valid),
    .tx_msg    (tx_msg)
  );

  sp_rx_store #(.RX_DEPTH(RX_DEPTH), .IDX_W(IDX_W), .PW(PW), .NW(NW)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rx_word_we),
    .wr_idx  (rx_word_idx[IDX_W-1:0]),
    .wr_data (rx_word_data),
    .commit  (rx_commit),
    .pop     (pop_ok),
    .rd_idx  (idx),
    .rd_data (rx_rd_word),
    .pending (rx_pend)
  );

  assign status_word = {err_q, {(32-1-CNT_BITS){1'b0}},
                        dir_rx ? CNT_BITS'(rx_pend) : CNT_BITS'(cred_cnt)};

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_rx <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_req && is_ctrl) begin
        dir_rx <= bus_wdata[31];
      end
      if (tx_err || pop_err) begin
        err_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_kind <= RSP_ZERO;
      snap_q   <= '0;
    end else begin
      rsp_kind <= RSP_ZERO;
      if (rd_req) begin
        if (is_status || is_ctrl) begin
          rsp_kind <= RSP_SNAP;
        end else if (is_data && dir_rx) begin
          rsp_kind <= RSP_MEM;
        end
        snap_q <= is_status ? status_word : {dir_rx, 31'b0};
      end
    end
  end

  always_comb begin
    case (rsp_kind)
      RSP_SNAP: bus_rdata = snap_q;
      RSP_MEM:  bus_rdata = rx_rd_word;
      default:  bus_rdata = '0;
    endcase
  end

  assign rx_irq = dir_rx && (rx_pend != '0);
endmodule

// File: rtl/sp_thread_chk.sv
module sp_thread_chk #(
  parameter int INIT_CREDITS = 4,
  parameter int RX_DEPTH     = 4,
  parameter int MSG_WORDS    = 15,
  parameter int CW           = 3,
  parameter int NW           = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [12:0]   bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          credit_ret,
  input logic          tx_valid,
  input logic          rx_irq,
  input logic          dir_rx,
  input logic          err_q,
  input logic [CW-1:0] cred_cnt,
  input logic [NW-1:0] rx_pend
);
  localparam logic [12:0] LAST_ADDR = 13'(4 * MSG_WORDS);
  localparam logic [12:0] CTRL_ADDR = 13'h1000;

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_TX_FROM_COMPLETION: assert property (@(posedge clk) disable iff (rst || !past_ok)
    tx_valid |-> $past(bus_valid && bus_write && (bus_addr == LAST_ADDR) && !dir_rx)); // R3

  AST_CRED_SPENT: assert property (@(posedge clk) disable iff (rst || !past_ok)
    tx_valid |-> (cred_cnt == ($past(cred_cnt) - CW'(1) + CW'($past(credit_ret))))); // R3

  AST_CRED_CEILING: assert property (@(posedge clk) disable iff (rst || !past_ok)
    cred_cnt <= CW'(INIT_CREDITS)); // R4

  AST_ZERO_CREDIT_ERR: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(bus_valid && bus_write && (bus_addr == LAST_ADDR) && !dir_rx) &&
     ($past(cred_cnt) == '0)) |-> (err_q && !tx_valid)); // R5

  AST_PEND_CEILING: assert property (@(posedge clk) disable iff (rst || !past_ok)
    rx_pend <= NW'(RX_DEPTH)); // R6

  AST_EMPTY_POP_ERR: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(bus_valid && !bus_write && (bus_addr == LAST_ADDR) && dir_rx) &&
     ($past(rx_pend) == '0)) |-> err_q); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst || !past_ok)
    err_q |=> err_q); // R9

  AST_IRQ_OFF_IN_TX: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(bus_valid && bus_write && (bus_addr == CTRL_ADDR) && !bus_wdata[31]) |-> !rx_irq); // R10

  AST_NO_TX_IN_RX: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(dir_rx) |-> !tx_valid); // R11
endmodule

bind sp_thread sp_thread_chk #(
  .INIT_CREDITS (INIT_CREDITS),
  .RX_DEPTH     (RX_DEPTH),
  .MSG_WORDS    (MSG_WORDS),
  .CW           (CW),
  .NW           (NW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .credit_ret (credit_ret),
  .tx_valid   (tx_valid),
  .rx_irq     (rx_irq),
  .dir_rx     (dir_rx),
  .err_q      (err_q),
  .cred_cnt   (cred_cnt),
  .rx_pend    (rx_pend)
);

// File: tb/sp_thread_bench.sv
module sp_thread_bench;
  localparam int INIT   = 4;
  localparam int DEPTH  = 4;
  localparam int NWORDS = 15;
  localparam int MBITS  = NWORDS * 32;
  localparam logic [12:0] A_STAT = 13'h0000;
  localparam logic [12:0] A_CTRL = 13'h1000;
  localparam logic [12:0] A_LAST = 13'h003C;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_valid = 1'b0;
  logic             bus_write = 1'b0;
  logic [12:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             credit_ret = 1'b0;
  logic             rx_word_we = 1'b0;
  logic [3:0]       rx_word_idx = '0;
  logic [31:0]      rx_word_data = '0;
  logic             rx_commit = 1'b0;
  logic             tx_valid;
  logic [MBITS-1:0] tx_msg;
  logic             rx_irq;

  always #4 clk = ~clk;

  sp_thread #(.INIT_CREDITS(INIT), .RX_DEPTH(DEPTH), .MSG_WORDS(NWORDS)) u_sp_thread (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .credit_ret(credit_ret), .rx_word_we(rx_word_we), .rx_word_idx(rx_word_idx),
    .rx_word_data(rx_word_data), .rx_commit(rx_commit), .tx_valid(tx_valid),
    .tx_msg(tx_msg), .rx_irq(rx_irq)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit chk_on = 1'b0;
  string cur_tag = "R2";

  // behavioural reference model
  int               m_cred, m_pend;
  bit               m_err, m_dir;
  logic [MBITS-1:0] m_stage, wbuf;
  logic [MBITS-1:0] rxq[$];
  bit               e_txv, e_irq, e_rdv, e_care;
  logic [MBITS-1:0] e_msg;
  logic [31:0]      e_rd;
  string            e_tag;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cred = INIT; m_err = 0; m_dir = 0; m_stage = '0; wbuf = '0;
      rxq.delete(); m_pend = 0;
      e_txv = 0; e_irq = 0; e_rdv = 0; e_care = 0;
    end else begin
      int  w, n;
      bit  dt, full, spend;
      w     = int'(bus_addr[12:2]);
      n     = w - 1;
      dt    = (bus_addr[1:0] == 2'b00) && (w >= 1) && (w <= NWORDS);
      full  = (m_pend == DEPTH);
      spend = 0;
      e_txv = 0; e_rdv = 0; e_care = 0;
      if (bus_valid && !bus_write) begin
        e_rdv = 1; e_care = 1; e_tag = cur_tag;
        if (bus_addr == A_STAT)
          e_rd = {m_err, 23'b0, 8'(m_dir ? m_pend : m_cred)};
        else if (bus_addr == A_CTRL)
          e_rd = {m_dir, 31'b0};
        else if (dt && m_dir) begin
          if (m_pend > 0) e_rd = rxq[0][32*n +: 32];
          else e_care = 0;
        end else
          e_rd = '0;
        if (dt && n == NWORDS - 1 && m_dir) begin
          if (m_pend > 0) void'(rxq.pop_front());
          else m_err = 1;
        end
      end
      if (bus_valid && bus_write) begin
        if (bus_addr == A_CTRL) m_dir = bus_wdata[31];
        else if (dt && !m_dir) begin
          if (n == NWORDS - 1) begin
            if (m_cred > 0) begin
              e_txv = 1; spend = 1;
              e_msg = {bus_wdata, m_stage[MBITS-33:0]};
            end else m_err = 1;
          end else m_stage[32*n +: 32] = bus_wdata;
        end
      end
      if (rx_word_we && !full) wbuf[32*int'(rx_word_idx) +: 32] = rx_word_data;
      if (rx_commit && !full) rxq.push_back(wbuf);
      if (spend && !credit_ret) m_cred--;
      else if (credit_ret && !spend && m_cred < INIT) m_cred++;
      m_pend = rxq.size();
      e_irq  = m_dir && (m_pend != 0);
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      checks++;
      if (tx_valid !== e_txv) begin
        errors++;
        $display("FAIL R3 tx_valid actual=%0b expected=%0b", tx_valid, e_txv);
      end
      checks++;
      if (rx_irq !== e_irq) begin
        errors++;
        $display("FAIL R10 rx_irq actual=%0b expected=%0b", rx_irq, e_irq);
      end
      if (e_txv) begin
        checks++;
        if (tx_msg !== e_msg) begin
          errors++;
          $display("FAIL R3 tx_msg actual=%h expected=%h", tx_msg, e_msg);
        end
      end
      if (e_rdv && e_care) begin
        checks++;
        if (bus_rdata !== e_rd) begin
          errors++;
          $display("FAIL %s bus_rdata actual=%h expected=%h", e_tag, bus_rdata, e_rd);
        end
      end
    end
  end

  task automatic idle_after_edge();
    @(posedge clk);
    #1;
    bus_valid = 0; bus_write = 0; credit_ret = 0; rx_word_we = 0; rx_commit = 0;
  endtask

  task automatic bus_wr(input logic [12:0] a, input logic [31:0] d, input bit cr = 0);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; credit_ret = cr;
    idle_after_edge();
  endtask

  task automatic bus_rd(input logic [12:0] a);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    idle_after_edge();
  endtask

  task automatic give_credit();
    @(negedge clk);
    credit_ret = 1;
    idle_after_edge();
  endtask

  task automatic send_msg(input int seed);
    for (int i = 0; i < NWORDS; i++)
      bus_wr(13'(4 + 4 * i), 32'(seed * 4096 + i * 17 + 5));
  endtask

  task automatic far_push(input int seed, input bit fill = 1);
    if (fill) begin
      for (int i = 0; i < NWORDS; i++) begin
        @(negedge clk);
        rx_word_we = 1; rx_word_idx = 4'(i); rx_word_data = 32'(seed * 65536 + i * 3 + 1);
        idle_after_edge();
      end
    end
    @(negedge clk);
    rx_commit = 1;
    idle_after_edge();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  always @(posedge clk) begin
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: run hung actual=%0d cycles expected<50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk_on = 1;
    // reset state
    cur_tag = "R3"; bus_rd(A_STAT);
    cur_tag = "R1"; bus_rd(A_CTRL);
    // transmit a message, credit spent
    send_msg(1);
    cur_tag = "R2"; bus_rd(A_STAT);
    cur_tag = "R12"; bus_rd(13'h0018);
    // transmit-side read of completion word has no effect
    cur_tag = "R11"; bus_rd(A_LAST); bus_rd(A_STAT);
    // credit return, saturation, simultaneous return with completion
    cur_tag = "R4"; give_credit(); give_credit(); bus_rd(A_STAT);
    bus_wr(13'h0004, 32'hA5A5_0001);
    bus_wr(A_LAST, 32'hC0DE_0001, 1);
    bus_rd(A_STAT);
    // drain credits then complete with zero credits
    for (int k = 0; k < INIT; k++) bus_wr(A_LAST, 32'(k + 100));
    cur_tag = "R5"; bus_wr(A_LAST, 32'hDEAD_0000); bus_rd(A_STAT);
    // error stays set through later good traffic
    cur_tag = "R9"; give_credit(); send_msg(2); bus_rd(A_STAT);
    do_reset(); bus_rd(A_STAT);
    // switch to receive; data writes have no effect
    cur_tag = "R1"; bus_wr(A_CTRL, 32'h8000_0000); bus_rd(A_CTRL);
    cur_tag = "R11"; bus_wr(13'h0008, 32'h1111_2222); bus_wr(A_LAST, 32'h3333_4444);
    bus_rd(A_STAT);
    // fill the receive store, then overflow attempts
    cur_tag = "R6";
    for (int m = 0; m < DEPTH; m++) begin far_push(m + 10); bus_rd(A_STAT); end
    far_push(99); bus_rd(A_STAT);
    // read head message word by word, last read pops
    cur_tag = "R7";
    for (int i = 0; i < NWORDS; i++) bus_rd(13'(4 + 4 * i));
    bus_rd(A_STAT);
    for (int m = 1; m < DEPTH; m++) begin bus_rd(13'h0010); bus_rd(A_LAST); end
    bus_rd(A_STAT);
    // pop with nothing pending
    cur_tag = "R8"; bus_rd(A_LAST); bus_rd(A_STAT);
    // interrupt drops when leaving receive direction
    cur_tag = "R10"; far_push(7); bus_wr(A_CTRL, 32'h0); bus_rd(A_STAT);
    bus_wr(A_CTRL, 32'h8000_0000); bus_rd(13'h0020);
    // back to transmit: staged words untouched by receive-side writes
    cur_tag = "R11"; bus_wr(A_CTRL, 32'h0); bus_wr(A_LAST, 32'h7777_8888); bus_rd(A_STAT);
    cur_tag = "R12"; bus_rd(13'h0004);
    repeat (4) @(posedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule